// File: doc/BRIEF.md
# UART Transmit Holding and Shift Path

This block is the transmit half of one 8-bit serial channel. A host places a byte into a one-entry holding stage with a single-cycle write strobe. As soon as the shift stage is free, the byte moves into it and the holding stage becomes free again, so the host can queue the next byte while the current one is still on the line. The shift stage sends each byte as a frame of ten bits: a low start bit, the eight data bits least significant first, and a high stop bit. Each bit holds for sixteen pulses of an external baud-enable strobe.

Two status outputs are meant for a line status register. `hold_empty` reports whether a new byte may be written. It goes high again as soon as the waiting byte is handed to the shift stage, not when the line falls quiet. `tx_idle` reports that nothing is waiting and nothing is being shifted. A write made while the holding stage is occupied is dropped, and it sets a sticky `overrun` flag that only reset clears.

Top module: `uart_tx_path`

## Requirements
- R1: While reset is asserted, and after it, `tx` = 1, `hold_empty` = 1, `tx_idle` = 1 and `overrun` = 0.
- R2: A write with `wr_en` = 1 while `hold_empty` = 1 captures `wr_data[7:0]`, and `hold_empty` reads 0 after that clock edge.
- R3: A byte that is waiting while the shift stage is idle moves into the shift stage on the next clock edge, and `hold_empty` returns to 1 at that edge.
- R4: Each frame on `tx` is one start bit at 0, then data bits 0 through 7 in that order, then one stop bit at 1.
- R5: Every bit of a frame lasts exactly 16 clock edges at which `baud_tick` = 1. `tx` changes only at an edge where `baud_tick` = 1, or at an edge where a byte is loaded.
- R6: A write made while `hold_empty` = 0 leaves the waiting byte unchanged. It sets `overrun` to 1, and `overrun` stays 1 until reset.
- R7: `tx_idle` is 1 only when no byte is waiting and the shift stage has finished its last stop bit.
- R8: If a byte is waiting when a stop bit ends, that byte's start bit begins at the same clock edge. No idle bit time is inserted and `tx_idle` stays 0.
- R9: When no frame is in progress, `tx` rests at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Baud enable, sixteen pulses per bit time |
| wr_en | input | 1 | Host write strobe for the holding stage |
| wr_data | input | 8 | Byte to transmit |
| tx | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding stage free for a write |
| tx_idle | output | 1 | Nothing waiting and nothing being shifted |
| overrun | output | 1 | Sticky flag for a dropped write |

## Verification
The bench uses the default parameters: 8 data bits and 16 ticks per bit. With these values one frame lasts 160 baud pulses, so a frame can be completed in a few hundred clocks even when the strobe is sparse. The strobe spacing is changed at run time. Stopping the strobe entirely holds a frame in place, which makes the holding stage fill and exercises dropped writes. Pulsing the strobe on every clock lets a waiting byte meet the end of a stop bit, which checks the back-to-back handoff.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Shift stage activity.
  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_BUSY = 1'b1
  } sh_state_e;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              overrun
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              ovr_q, ovr_d;

  // Next state: a transfer frees the slot, and a write fills an empty slot or flags overrun.
  always_comb begin
    full_d = full_q;
    data_d = data_q;
    ovr_d  = ovr_q;
    if (take) begin
      full_d = 1'b0;
    end
    if (wr_en) begin
      if (!full_q) begin
        full_d = 1'b1;
        data_d = wr_data;
      end else begin
        ovr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
      ovr_q  <= ovr_d;
    end
  end

  assign full    = full_q;
  assign data    = data_q;
  assign overrun = ovr_q;

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full_q) |=> (full_q && data_q == $past(wr_data)));

  // R6
  ign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full_q) |=> (data_q == $past(data_q)));

  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              load_req,
  input  logic [DATA_W-1:0] load_data,
  output logic              load_ack,
  output logic              busy,
  output logic              tx
);

  localparam int FRAME_LEN = DATA_W + 2;
  localparam int TICK_W    = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int BIT_W     = $clog2(FRAME_LEN);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OSR - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(FRAME_LEN - 1);

  sh_state_e              state_q, state_d;
  logic [FRAME_LEN-1:0]   frame_q, frame_d;
  logic [TICK_W-1:0]      tick_q, tick_d;
  logic [BIT_W-1:0]       bit_q, bit_d;
  logic                   bit_done;
  logic                   frame_end;

  assign bit_done  = baud_tick && (tick_q == TICK_LAST);
  assign frame_end = (state_q == SH_BUSY) && bit_done && (bit_q == BIT_LAST);
  assign load_ack  = load_req && ((state_q == SH_IDLE) || frame_end);

  always_comb begin
    state_d = state_q;
    frame_d = frame_q;
    tick_d  = tick_q;
    bit_d   = bit_q;
    if (load_ack) begin
      state_d = SH_BUSY;
      frame_d = {1'b1, load_data, 1'b0};
      tick_d  = '0;
      bit_d   = '0;
    end else if ((state_q == SH_BUSY) && baud_tick) begin
      if (bit_done) begin
        tick_d  = '0;
        frame_d = {1'b1, frame_q[FRAME_LEN-1:1]};
        if (bit_q == BIT_LAST) begin
          state_d = SH_IDLE;
        end else begin
          bit_d = bit_q + BIT_W'(1);
        end
      end else begin
        tick_d = tick_q + TICK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      frame_q <= '1;
      tick_q  <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_d;
      tick_q  <= tick_d;
      bit_q   <= bit_d;
    end
  end

  assign busy = (state_q == SH_BUSY);
  assign tx   = busy ? frame_q[0] : 1'b1;

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick && !load_ack) |=> $stable(tx));

  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ack |=> (busy && !tx));

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx,
  output logic              hold_empty,
  output logic              tx_idle,
  output logic              overrun
);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              xfer;
  logic              sh_busy;

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (xfer),
    .full    (hold_full),
    .data    (hold_data),
    .overrun (overrun)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .OSR(OSR)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .load_req  (hold_full),
    .load_data (hold_data),
    .load_ack  (xfer),
    .busy      (sh_busy),
    .tx        (tx)
  );

  assign hold_empty = !hold_full;
  assign tx_idle    = !hold_full && !sh_busy;

  // R3
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !sh_busy) |=> (!hold_full && sh_busy));

  // R8
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_busy && hold_full) |=> sh_busy);

endmodule

// File: tb/test_uart_tx_path.sv
module test_uart_tx_path;

  localparam int CLK_PERIOD = 10;
  localparam int OSR        = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx, hold_empty, tx_idle, overrun;

  int checks = 0;
  int fails  = 0;
  int tick_per = 1000000;
  int tick_ctr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_path #(.DATA_W(8), .OSR(OSR)) i_uart_tx_path (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .tx(tx), .hold_empty(hold_empty),
    .tx_idle(tx_idle), .overrun(overrun)
  );

  // Behavioural reference: a waiting-byte queue and a queue of line bits still to send.
  logic [7:0] m_wait[$];
  bit         m_line[$];
  int         m_tk;
  bit         m_ovr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wait.delete(); m_line.delete(); m_tk = 0; m_ovr = 0;
    end else begin
      bit can_load, had_wait;
      logic [7:0] b;
      had_wait = (m_wait.size() != 0);
      can_load = (m_line.size() == 0) ||
                 (m_line.size() == 1 && baud_tick && m_tk == OSR-1);
      if (m_line.size() != 0 && baud_tick) begin
        if (m_tk == OSR-1) begin m_tk = 0; void'(m_line.pop_front()); end
        else m_tk++;
      end
      if (had_wait && can_load) begin
        b = m_wait.pop_front();
        m_line.delete();
        m_tk = 0;
        m_line.push_back(1'b0);
        for (int i = 0; i < 8; i++) m_line.push_back(b[i]);
        m_line.push_back(1'b1);
      end
      if (wr_en) begin
        if (had_wait) m_ovr = 1;
        else m_wait.push_back(wr_data);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the reference.
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_tx;
      e_tx = (m_line.size() != 0) ? m_line[0] : 1'b1;
      check(tx == e_tx, "R4 tx", tx, e_tx);
      check(hold_empty == (m_wait.size() == 0), "R2 hold_empty", hold_empty, m_wait.size() == 0);
      check(tx_idle == (m_wait.size() == 0 && m_line.size() == 0), "R7 tx_idle",
            tx_idle, m_wait.size() == 0 && m_line.size() == 0);
      check(overrun == m_ovr, "R6 overrun", overrun, m_ovr);
    end
  end

  task automatic step(input logic we, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = we; wr_data = d;
    tick_ctr++;
    if (tick_ctr >= tick_per) begin tick_ctr = 0; baud_tick = 1'b1; end
    else baud_tick = 1'b0;
  endtask

  task automatic idle_steps(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00);
  endtask

  task automatic reset_check();
    check(tx == 1'b1, "R1 tx", tx, 1);
    check(hold_empty == 1'b1, "R1 hold_empty", hold_empty, 1);
    check(tx_idle == 1'b1, "R1 tx_idle", tx_idle, 1);
    check(overrun == 1'b0, "R1 overrun", overrun, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit last_tick;
    int cnt;
    bit saw_idle;
    idle_steps(3);
    reset_check();
    rst_n = 1'b1;
    idle_steps(2);
    reset_check();
    check(tx == 1'b1, "R9 rest", tx, 1);

    // R2, R3: strobe frozen, write from idle.
    tick_per = 1000000;
    step(1'b1, 8'hA5);
    step(1'b0, 8'h00);
    check(hold_empty == 1'b0, "R2 captured", hold_empty, 0);
    step(1'b0, 8'h00);
    check(hold_empty == 1'b1, "R3 handoff", hold_empty, 1);
    check(tx == 1'b0, "R4 start", tx, 0);

    // R6: fill the slot while frozen, then write again.
    step(1'b1, 8'h3C);
    step(1'b1, 8'hFF);
    step(1'b0, 8'h00);
    check(overrun == 1'b1, "R6 overrun set", overrun, 1);
    check(hold_empty == 1'b0, "R6 slot still full", hold_empty, 0);

    // R8: strobe every clock; the waiting byte must follow without a gap.
    tick_per = 1;
    saw_idle = 0;
    for (int i = 0; i < 170 && !hold_empty; i++) begin
      step(1'b0, 8'h00);
      if (tx_idle) saw_idle = 1;
    end
    check(hold_empty == 1'b1, "R8 loaded", hold_empty, 1);
    check(tx == 1'b0, "R8 start follows", tx, 0);
    check(!saw_idle, "R8 no idle", saw_idle, 0);
    idle_steps(200);
    check(tx_idle == 1'b1 && tx == 1'b1, "R7 drained", tx_idle, 1);
    check(overrun == 1'b1, "R6 sticky", overrun, 1);

    // R5: count strobe pulses over the start bit with sparse strobes.
    tick_per = 3;
    step(1'b1, 8'h01);
    while (tx) step(1'b0, 8'h00);
    last_tick = baud_tick;
    cnt = 0;
    forever begin
      step(1'b0, 8'h00);
      if (last_tick) cnt++;
      if (tx) break;
      last_tick = baud_tick;
    end
    check(cnt == OSR, "R5 bit length", cnt, OSR);
    idle_steps(520);

    // Mixed traffic with varying strobe spacing and overlapping writes.
    for (int k = 0; k < 6; k++) begin
      tick_per = 1 + (k % 4);
      step(1'b1, 8'($urandom));
      idle_steps(k * 7);
      step(1'b1, 8'($urandom));
      idle_steps(40 + k * 50);
    end
    idle_steps(1400);
    check(tx_idle == 1'b1, "R7 final idle", tx_idle, 1);

    // R1: asynchronous reset mid-frame.
    step(1'b1, 8'h55);
    idle_steps(20);
    @(negedge clk); #1; rst_n = 1'b0;
    idle_steps(2);
    reset_check();
    rst_n = 1'b1;
    idle_steps(3);
    reset_check();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule